// File: doc/BRIEF.md
# Serial Flash Write-Protection Gate

This block sits beside the instruction decoder of a serial NOR flash and rules on every decoded instruction: it either lets the instruction run or turns it away. The ruling combines several independent layers of protection. A supply-good input holds the gate in reset while it is low. A hold-off timer blocks every instruction that could alter stored data for a fixed number of cycles after power returns. A write-enable latch arms program, erase and status writes and clears itself afterwards. A sleep state lets only the wake instruction through. A two-bit status-protect field, together with the hardware write-protect pin level, decides whether the status register may be rewritten.

The decoder presents one strobe per instruction with a class code. It also reports the rising edge of chip select that ends the instruction, and a pulse when an internal program, erase or status write has finished. The decoder resolves whether the addressed region is block-protected and passes that in as a single flag. For chip erase, the flag means that any region is protected. The gate answers each strobe with a one-cycle accept or reject pulse, and it exports the latch and sleep state.

Top module: `flash_wp_gate`

## Requirements
- R1: While `pwrGood` is low, all state is reset: `cmdAccept`, `cmdReject`, `welState` and `pwrDown` are all 0, and strobes get no response.
- R2: Count rising clock edges from the edge after `pwrGood` rises, starting at N=1. A hold-off-gated instruction sampled on edge N is rejected when N ≤ HOLD_CYCLES. The gated classes are WREN, PROG, SECT, BLK, CHIP and WRSR. From edge HOLD_CYCLES+1 onward the other rules decide. Ungated classes are never held off.
- R3: Every `cmdValid` strobe produces exactly one of `cmdAccept` or `cmdReject`, as a one-cycle pulse in the next cycle. Class codes: 0 READ, 1 WREN, 2 WRDI, 3 PROG, 4 SECT, 5 BLK, 6 CHIP, 7 WRSR, 8 SLEEP, 9 WAKE. Any other code is an ordinary ungated instruction.
- R4: `welState` is 0 after power-up. An accepted WREN sets it and an accepted WRDI clears it. The change happens at the clock edge that samples the following `csRise`, and not before.
- R5: PROG, SECT, BLK, CHIP and WRSR are rejected while `welState` is 0, and the latch stays 0.
- R6: An `opDone` pulse clears `welState` at the edge that samples it. This takes precedence over any pending set.
- R7: PROG, SECT, BLK or CHIP with `areaLocked` high is rejected, and the same edge clears `welState`.
- R8: With `welState` at 1, WRSR depends on `srpBits`. For 00 it is accepted. For 01 it is accepted only when `wpLevel` is 1. For 10 and 11 it is always rejected.
- R9: An accepted SLEEP sets `pwrDown` at the edge that samples the next `csRise`. While `pwrDown` is 1, every class except WAKE is rejected and leaves `welState` unchanged. WAKE is accepted and clears `pwrDown` at the next `csRise`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| pwrGood | input | 1 | Supply above write-inhibit level; low resets the gate asynchronously |
| cmdValid | input | 1 | One-cycle strobe for a decoded instruction |
| cmdClass | input | 4 | Class code of the instruction (see R3) |
| csRise | input | 1 | One-cycle pulse on the chip-select rising edge |
| opDone | input | 1 | One-cycle pulse when a program, erase or status write finishes |
| srpBits | input | 2 | Status-protect field |
| areaLocked | input | 1 | Addressed region (any region for CHIP) is block-protected |
| wpLevel | input | 1 | Level of the active-low hardware write-protect pin |
| cmdAccept | output | 1 | Instruction accepted, one cycle after the strobe |
| cmdReject | output | 1 | Instruction rejected, one cycle after the strobe |
| welState | output | 1 | Write-enable latch |
| pwrDown | output | 1 | Sleep state |

## Verification
The main sweep covers every class code. Each code is tried against both latch values, both sleep states, all four status-protect encodings, both pin levels and both lock-flag values. This separates the latch gate, the block-lock path that clears the latch, the status-protect decode and the sleep filter from one another. A separate power-cycle sequence issues WREN, WRDI and READ on the last edge of the hold-off window and on the first edge after it. This exposes an off-by-one in the timer and any hold-off applied to ungated classes. After each probe, a chip-select pulse and a completion pulse show whether the deferred latch and sleep updates landed on the intended edge.

// File: rtl/wp_pkg.sv
package wp_pkg;

  typedef enum logic [3:0] {
    CLS_READ  = 4'd0,
    CLS_WREN  = 4'd1,
    CLS_WRDI  = 4'd2,
    CLS_PROG  = 4'd3,
    CLS_SECT  = 4'd4,
    CLS_BLK   = 4'd5,
    CLS_CHIP  = 4'd6,
    CLS_WRSR  = 4'd7,
    CLS_SLEEP = 4'd8,
    CLS_WAKE  = 4'd9
  } cmd_class_e;

  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_SET  = 2'd1,
    PEND_CLR  = 2'd2
  } pend_e;

  // strobes from the decision logic to the state datapath
  typedef struct packed {
    logic accept;
    logic reject;
    logic welArmSet;
    logic welArmClr;
    logic welKill;
    logic pdArmEnter;
    logic pdArmExit;
  } gate_strobe_t;

  // classes blocked during the power-up hold-off
  function automatic logic isHeldOff(input logic [3:0] cls);
    return (cls == CLS_WREN) || (cls == CLS_PROG) || (cls == CLS_SECT) ||
           (cls == CLS_BLK)  || (cls == CLS_CHIP) || (cls == CLS_WRSR);
  endfunction

  // classes that need the write-enable latch
  function automatic logic needsWel(input logic [3:0] cls);
    return (cls == CLS_PROG) || (cls == CLS_SECT) || (cls == CLS_BLK) ||
           (cls == CLS_CHIP) || (cls == CLS_WRSR);
  endfunction

  // classes that touch the array and honour block protection
  function automatic logic touchesArray(input logic [3:0] cls);
    return (cls == CLS_PROG) || (cls == CLS_SECT) || (cls == CLS_BLK) ||
           (cls == CLS_CHIP);
  endfunction

endpackage

// File: rtl/wp_holdoff.sv
module wp_holdoff #(
  parameter int HOLD_CYCLES = 8,
  localparam int CntW = $clog2(HOLD_CYCLES + 1)
) (
  input  logic clk,
  input  logic pwrGood,
  output logic holdDone
);

  localparam logic [CntW-1:0] HoldLimit = CntW'(HOLD_CYCLES);

  logic [CntW-1:0] holdCnt;

  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood) begin
      holdCnt <= '0;
    end else if (holdCnt != HoldLimit) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  assign holdDone = (holdCnt == HoldLimit);

  // R2
  hold_cnt_range_chk: assert property (@(posedge clk) disable iff (!pwrGood)
    holdCnt <= HoldLimit);

  // R2
  hold_sticky_chk: assert property (@(posedge clk) disable iff (!pwrGood)
    holdDone |=> holdDone);

endmodule

// File: rtl/wp_decide.sv
module wp_decide
  import wp_pkg::*;
(
  input  logic         cmdValid,
  input  logic [3:0]   cmdClass,
  input  logic         holdDone,
  input  logic         welState,
  input  logic         pwrDown,
  input  logic [1:0]   srpBits,
  input  logic         areaLocked,
  input  logic         wpLevel,
  output gate_strobe_t strb
);

  logic srpAllows;

  always_comb begin
    unique case (srpBits)
      2'b00:   srpAllows = 1'b1;
      2'b01:   srpAllows = wpLevel;
      default: srpAllows = 1'b0;
    endcase
  end

  always_comb begin
    strb = '0;
    if (cmdValid) begin
      if (pwrDown) begin
        if (cmdClass == CLS_WAKE) begin
          strb.accept    = 1'b1;
          strb.pdArmExit = 1'b1;
        end else begin
          strb.reject = 1'b1;
        end
      end else if (isHeldOff(cmdClass) && !holdDone) begin
        strb.reject = 1'b1;
      end else if (needsWel(cmdClass) && !welState) begin
        strb.reject = 1'b1;
      end else if (touchesArray(cmdClass) && areaLocked) begin
        strb.reject  = 1'b1;
        strb.welKill = 1'b1;
      end else if ((cmdClass == CLS_WRSR) && !srpAllows) begin
        strb.reject = 1'b1;
      end else begin
        strb.accept = 1'b1;
        case (cmdClass)
          CLS_WREN:  strb.welArmSet  = 1'b1;
          CLS_WRDI:  strb.welArmClr  = 1'b1;
          CLS_SLEEP: strb.pdArmEnter = 1'b1;
          CLS_WAKE:  strb.pdArmExit  = 1'b1;
          default:   ;
        endcase
      end
    end
  end

endmodule

// File: rtl/wp_state.sv
module wp_state
  import wp_pkg::*;
(
  input  logic         clk,
  input  logic         pwrGood,
  input  gate_strobe_t strb,
  input  logic         csRise,
  input  logic         opDone,
  output logic         cmdAccept,
  output logic         cmdReject,
  output logic         welState,
  output logic         pwrDown
);

  pend_e welPend, pdPend;
  pend_e welEff, pdEff;

  always_comb begin
    if (strb.welArmSet)      welEff = PEND_SET;
    else if (strb.welArmClr) welEff = PEND_CLR;
    else                     welEff = welPend;
    if (strb.pdArmEnter)     pdEff = PEND_SET;
    else if (strb.pdArmExit) pdEff = PEND_CLR;
    else                     pdEff = pdPend;
  end

  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood) begin
      cmdAccept <= 1'b0;
      cmdReject <= 1'b0;
      welState  <= 1'b0;
      pwrDown   <= 1'b0;
      welPend   <= PEND_NONE;
      pdPend    <= PEND_NONE;
    end else begin
      cmdAccept <= strb.accept;
      cmdReject <= strb.reject;
      welPend   <= csRise ? PEND_NONE : welEff;
      pdPend    <= csRise ? PEND_NONE : pdEff;
      if (opDone || strb.welKill) begin
        welState <= 1'b0;
      end else if (csRise && (welEff == PEND_SET)) begin
        welState <= 1'b1;
      end else if (csRise && (welEff == PEND_CLR)) begin
        welState <= 1'b0;
      end
      if (csRise && (pdEff == PEND_SET)) begin
        pwrDown <= 1'b1;
      end else if (csRise && (pdEff == PEND_CLR)) begin
        pwrDown <= 1'b0;
      end
    end
  end

  // R3
  single_verdict_chk: assert property (@(posedge clk) disable iff (!pwrGood)
    !(cmdAccept && cmdReject));

  // R6
  op_done_clears_wel_chk: assert property (@(posedge clk) disable iff (!pwrGood)
    opDone |=> !welState);

  // R4
  wel_rise_on_cs_chk: assert property (@(posedge clk) disable iff (!pwrGood)
    $rose(welState) |-> $past(csRise));

  // R9
  sleep_moves_on_cs_chk: assert property (@(posedge clk) disable iff (!pwrGood)
    !$stable(pwrDown) |-> $past(csRise));

endmodule

// File: rtl/flash_wp_gate.sv
module flash_wp_gate
  import wp_pkg::*;
#(
  parameter int HOLD_CYCLES = 8
) (
  input  logic       clk,
  input  logic       pwrGood,
  input  logic       cmdValid,
  input  logic [3:0] cmdClass,
  input  logic       csRise,
  input  logic       opDone,
  input  logic [1:0] srpBits,
  input  logic       areaLocked,
  input  logic       wpLevel,
  output logic       cmdAccept,
  output logic       cmdReject,
  output logic       welState,
  output logic       pwrDown
);

  logic         holdDone;
  gate_strobe_t strb;

  wp_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) uHold (
    .clk      (clk),
    .pwrGood  (pwrGood),
    .holdDone (holdDone)
  );

  wp_decide uDecide (
    .cmdValid   (cmdValid),
    .cmdClass   (cmdClass),
    .holdDone   (holdDone),
    .welState   (welState),
    .pwrDown    (pwrDown),
    .srpBits    (srpBits),
    .areaLocked (areaLocked),
    .wpLevel    (wpLevel),
    .strb       (strb)
  );

  wp_state uState (
    .clk       (clk),
    .pwrGood   (pwrGood),
    .strb      (strb),
    .csRise    (csRise),
    .opDone    (opDone),
    .cmdAccept (cmdAccept),
    .cmdReject (cmdReject),
    .welState  (welState),
    .pwrDown   (pwrDown)
  );

  // R1
  always @(posedge clk) begin
    if (!pwrGood) begin
      power_off_quiet_chk: assert (!cmdAccept && !cmdReject && !welState && !pwrDown);
    end
  end

  // R3
  one_verdict_per_cmd_chk: assert property (@(posedge clk) disable iff (!pwrGood)
    cmdValid |=> (cmdAccept ^ cmdReject));

  // R2
  holdoff_rejects_chk: assert property (@(posedge clk) disable iff (!pwrGood)
    (cmdValid && !pwrDown && !holdDone && isHeldOff(cmdClass)) |=> cmdReject);

  // R5
  no_wel_rejects_chk: assert property (@(posedge clk) disable iff (!pwrGood)
    (cmdValid && !pwrDown && !welState && needsWel(cmdClass)) |=> cmdReject);

  // R9
  sleep_filter_chk: assert property (@(posedge clk) disable iff (!pwrGood)
    (cmdValid && pwrDown && (cmdClass != CLS_WAKE)) |=> cmdReject);

endmodule

// File: tb/sim_flash_wp_gate.sv
`timescale 1ns/1ps
module sim_flash_wp_gate;

  localparam int Hold = 6;

  logic       clk = 1'b0;
  logic       pwrGood = 1'b0;
  logic       cmdValid = 1'b0;
  logic [3:0] cmdClass = 4'd0;
  logic       csRise = 1'b0;
  logic       opDone = 1'b0;
  logic [1:0] srpBits = 2'b00;
  logic       areaLocked = 1'b0;
  logic       wpLevel = 1'b1;
  logic       cmdAccept, cmdReject, welState, pwrDown;

  int checks = 0;
  int errors = 0;
  bit lastAcc;
  bit lastRej;

  always #5 clk = ~clk;

  flash_wp_gate #(.HOLD_CYCLES(Hold)) u0 (
    .clk(clk), .pwrGood(pwrGood), .cmdValid(cmdValid), .cmdClass(cmdClass),
    .csRise(csRise), .opDone(opDone), .srpBits(srpBits),
    .areaLocked(areaLocked), .wpLevel(wpLevel),
    .cmdAccept(cmdAccept), .cmdReject(cmdReject),
    .welState(welState), .pwrDown(pwrDown)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic issue(input int cls);
    cmdClass = 4'(cls);
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    lastAcc = cmdAccept;
    lastRej = cmdReject;
  endtask

  task automatic csPulse();
    csRise = 1'b1;
    @(negedge clk);
    csRise = 1'b0;
  endtask

  task automatic donePulse();
    opDone = 1'b1;
    @(negedge clk);
    opDone = 1'b0;
  endtask

  task automatic powerCycle();
    @(negedge clk);
    pwrGood = 1'b0;
    @(negedge clk);
    @(negedge clk);
    pwrGood = 1'b1;
  endtask

  function automatic bit heldClass(input int c);
    return c == 1 || (c >= 3 && c <= 7);
  endfunction

  function automatic bit expAccept(input int c, input bit wel, input bit pd,
                                   input int srp, input bit wp, input bit lk);
    if (pd) return c == 9;
    if (c >= 3 && c <= 7 && !wel) return 0;
    if (c >= 3 && c <= 6 && lk) return 0;
    if (c == 7) return (srp == 0) || (srp == 1 && wp);
    return 1;
  endfunction

  function automatic string reasonTag(input int c, input bit wel, input bit pd,
                                      input bit lk);
    if (pd) return "R9";
    if (c >= 3 && c <= 7 && !wel) return "R5";
    if (c >= 3 && c <= 6 && lk) return "R7";
    if (c == 7) return "R8";
    return "R3";
  endfunction

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: strobe while power is not good
    repeat (3) @(negedge clk);
    issue(1);
    chk(!lastAcc && !lastRej, "R1", "verdict during reset", {lastAcc, lastRej}, 0);
    chk(!welState && !pwrDown, "R1", "state during reset", {welState, pwrDown}, 0);

    // R2: last held edge versus first free edge
    for (int e = Hold; e <= Hold + 1; e++) begin
      for (int k = 0; k < 3; k++) begin
        int c;
        bit expA;
        c = (k == 0) ? 1 : (k == 1) ? 2 : 0;
        powerCycle();
        chk(welState == 1'b0, "R4", "latch after power-up", welState, 0);
        repeat (e - 1) @(negedge clk);
        issue(c);
        expA = heldClass(c) ? (e > Hold) : 1'b1;
        chk(lastAcc == expA && lastRej == !expA, "R2", $sformatf("class %0d edge %0d", c, e),
            lastAcc, expA);
        csPulse();
      end
    end

    // R2: ungated instruction on the very first edge
    powerCycle();
    issue(0);
    chk(lastAcc == 1'b1, "R2", "READ on edge 1", lastAcc, 1);

    // main sweep
    powerCycle();
    repeat (Hold + 2) @(negedge clk);
    for (int c = 0; c < 10; c++) begin
      for (int w = 0; w < 2; w++) begin
        for (int p = 0; p < 2; p++) begin
          for (int s = 0; s < 4; s++) begin
            for (int wp = 0; wp < 2; wp++) begin
              for (int lk = 0; lk < 2; lk++) begin
                bit expA;
                bit welMid;
                bit welEnd;
                bit pdEnd;
                srpBits = 2'(s);
                wpLevel = wp[0];
                areaLocked = 1'b0;
                if (w == 1) begin
                  issue(1);
                  csPulse();
                end
                if (p == 1) begin
                  issue(8);
                  csPulse();
                end
                chk(welState == w[0], "R4", "latch setup", welState, w);
                chk(pwrDown == p[0], "R9", "sleep setup", pwrDown, p);
                areaLocked = lk[0];
                issue(c);
                expA = expAccept(c, w[0], p[0], s, wp[0], lk[0]);
                chk(lastAcc == expA && lastRej == !expA,
                    reasonTag(c, w[0], p[0], lk[0]),
                    $sformatf("verdict c%0d w%0d p%0d s%0d wp%0d lk%0d", c, w, p, s, wp, lk),
                    lastAcc, expA);
                welMid = (!p[0] && c >= 3 && c <= 6 && w[0] && lk[0]) ? 1'b0 : w[0];
                chk(welState == welMid, (welMid != w[0]) ? "R7" : "R5",
                    "latch after verdict", welState, welMid);
                areaLocked = 1'b0;
                csPulse();
                welEnd = welMid;
                if (expA && c == 1) welEnd = 1'b1;
                if (expA && c == 2) welEnd = 1'b0;
                pdEnd = p[0];
                if (expA && c == 8) pdEnd = 1'b1;
                if (expA && c == 9) pdEnd = 1'b0;
                chk(welState == welEnd, "R4", "latch after chip select", welState, welEnd);
                chk(pwrDown == pdEnd, "R9", "sleep after chip select", pwrDown, pdEnd);
                if (pwrDown) begin
                  issue(9);
                  chk(lastAcc == 1'b1, "R9", "wake accepted", lastAcc, 1);
                  csPulse();
                  chk(pwrDown == 1'b0, "R9", "wake clears sleep", pwrDown, 0);
                end
                donePulse();
                chk(welState == 1'b0, "R6", "completion clears latch", welState, 0);
              end
            end
          end
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule